// File: doc/BRIEF.md
# Configuration Store Loader with CRC-Gated Start

This block keeps a small array of one-shot configuration lines that models a multiple-time-programmable cell store. Each line holds one configuration word, a CRC-16 of that word and a write-order stamp. A line starts blank and, once written, stays used until the whole store is blanked. The cell contents survive a power-on reset of the surrounding logic. Only the separate blank input, which stands in for a factory erase, clears them.

After every power-on reset the loader picks the line written most recently and recomputes its CRC. If the CRC matches, the word is copied into the operating configuration output and the start-enable output is raised. If it does not match, start-enable stays low and a CRC-failure flag is set. Software drives a simple command port. A WRITE goes to an unused line and holds the operation state busy for a programmable latency. A READ reports the stored word together with whether it passes its CRC. Software polls the operation state until it reads IDLE, and a write is verified by reading the same line back.

Top module: `cfgstore_top`

## Requirements
- R1: The operation state uses the codes IDLE=0, WRITE=1, READ=2, LOAD=3. After a power-on reset is released, the state is LOAD for exactly one cycle and then IDLE.
- R2: The load selects the used line that was written most recently, which is not necessarily the one with the highest index. When its CRC matches, the load copies that line's word to `cfgOut` and raises `startEn`.
- R3: The CRC is CRC-16 with polynomial 0x1021 and initial value 0xFFFF, processed MSB first over the 16-bit word with no final XOR. If the selected line fails this check, `startEn` stays 0, `crcFail` is 1 and `cfgOut` is 0. A blank store gives `startEn`=0 and `crcFail`=0. `startEn` and `crcFail` are never both 1.
- R4: `cfgOut`, `startEn` and `crcFail` change only at a load, never because of a WRITE or a READ.
- R5: An accepted WRITE (cmdOp=2'b01) holds the state at WRITE for exactly WR_LAT cycles. It then returns to IDLE with the line marked used and `linesUsed` increased by one. `linesUsed` never exceeds NUM_LINES.
- R6: A WRITE is rejected when it targets a used line, when it targets a line index at or above NUM_LINES, or when all lines are used. A rejected WRITE sets `wrErr`, changes no line and no count, and leaves the state at IDLE. The next accepted command clears `wrErr`.
- R7: A READ (cmdOp=2'b10) holds the state at READ for one cycle. It returns the stored word on `readData`, and `readOk` is 1 only when the line is used and its stored CRC matches.
- R8: A READ of an unused line gives `readOk`=0.
- R9: A command presented while the state is not IDLE is ignored. The cmdOp codes 2'b00 and 2'b11 are ignored in every state.
- R10: Stored lines and `linesUsed` survive a power-on reset, which reloads from them. Driving `blankN` low returns every line to unused.
- R11: When power-on reset cuts off a WRITE during its latency, the line stays used with its word stored and its CRC field left at the blank value 0. Both READ and the load then judge that line by the CRC check.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| porN | input | 1 | Active-low power-on reset of the logic; cells are kept |
| blankN | input | 1 | Active-low erase of every cell line |
| cmdValid | input | 1 | Command strobe, sampled in IDLE |
| cmdOp | input | 2 | 01 WRITE, 10 READ, others ignored |
| cmdLine | input | LINE_W (3) | Target line index |
| cmdData | input | DATA_W (16) | Word to write |
| opState | output | 2 | Operation state for polling |
| wrErr | output | 1 | Last WRITE was rejected |
| readOk | output | 1 | Last READ found a used line with a matching CRC |
| readData | output | DATA_W (16) | Word returned by the last READ |
| linesUsed | output | CNT_W (3) | Number of used lines |
| cfgOut | output | DATA_W (16) | Operating configuration loaded at power-up |
| startEn | output | 1 | Controller start permitted |
| crcFail | output | 1 | The line selected at power-up failed its CRC |

## Verification
The bench fills every line of a blank store in a scrambled index order with distinct words, and reads each line back after writing it. This tells apart a write that lands on the wrong line or stores the wrong word. Rewrites of used lines, out-of-range indices and commands sent during a busy write are mixed in, which separates correct rejection from silent corruption. The reload cases distinguish "newest by write order" from "highest index", because a lower index is written last. A write cut off by reset gives an expected outcome computed from the CRC of the interrupted word, so the bench tests the real check and not a flag.

// File: rtl/cfgstore_pkg.sv
package cfgstore_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_LOAD  = 2'd3
  } opState_e;

  localparam logic [1:0]  CMD_WRITE = 2'b01;
  localparam logic [1:0]  CMD_READ  = 2'b10;
  localparam logic [15:0] CRC_POLY  = 16'h1021;
  localparam logic [15:0] CRC_SEED  = 16'hFFFF;
  localparam logic [15:0] CRC_BLANK = 16'h0000;

  // strobes from the sequencer to the storage datapath
  typedef struct packed {
    logic ldCapture;  // latch the power-up selection result
    logic wrStart;    // program word, stamp and used flag
    logic wrCommit;   // program the CRC field at end of latency
    logic wrReject;   // flag a refused WRITE
    logic rdCapture;  // latch a READ result
  } ctrlStrobe_t;

endpackage

// File: rtl/cfgstore_ctrl.sv
module cfgstore_ctrl
  import cfgstore_pkg::*;
#(
  parameter int WR_LAT = 8
) (
  input  logic        clk,
  input  logic        porN,
  input  logic        cmdValid,
  input  logic [1:0]  cmdOp,
  input  logic        wrBlocked,
  output opState_e    opState,
  output ctrlStrobe_t strobe
);

  localparam int LAT_W = (WR_LAT < 2) ? 1 : $clog2(WR_LAT);
  localparam logic [LAT_W-1:0] LAT_LAST = LAT_W'(WR_LAT - 1);

  opState_e         stateQ, stateD;
  logic [LAT_W-1:0] latQ, latD;

  always_comb begin
    strobe = '0;
    stateD = stateQ;
    latD   = latQ;
    unique case (stateQ)
      OP_LOAD: begin
        strobe.ldCapture = 1'b1;
        stateD           = OP_IDLE;
      end
      OP_IDLE: begin
        if (cmdValid) begin
          if (cmdOp == CMD_WRITE) begin
            if (wrBlocked) begin
              strobe.wrReject = 1'b1;
            end else begin
              strobe.wrStart = 1'b1;
              latD           = LAT_LAST;
              stateD         = OP_WRITE;
            end
          end else if (cmdOp == CMD_READ) begin
            strobe.rdCapture = 1'b1;
            stateD           = OP_READ;
          end
        end
      end
      OP_WRITE: begin
        if (latQ == '0) begin
          strobe.wrCommit = 1'b1;
          stateD          = OP_IDLE;
        end else begin
          latD = latQ - 1'b1;
        end
      end
      OP_READ: stateD = OP_IDLE;
      default: stateD = OP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      stateQ <= OP_LOAD;
      latQ   <= '0;
    end else begin
      stateQ <= stateD;
      latQ   <= latD;
    end
  end

  assign opState = stateQ;

endmodule

// File: rtl/cfgstore_dp.sv
module cfgstore_dp
  import cfgstore_pkg::*;
#(
  parameter int NUM_LINES = 6,
  parameter int DATA_W    = 16,
  parameter int LINE_W    = 3,
  parameter int CNT_W     = 3
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              blankN,
  input  ctrlStrobe_t       strobe,
  input  logic [LINE_W-1:0] cmdLine,
  input  logic [DATA_W-1:0] cmdData,
  output logic              wrBlocked,
  output logic              wrErr,
  output logic              readOk,
  output logic [DATA_W-1:0] readData,
  output logic [CNT_W-1:0]  linesUsed,
  output logic [DATA_W-1:0] cfgOut,
  output logic              startEn,
  output logic              crcFail
);

  function automatic logic [15:0] crcOf(input logic [DATA_W-1:0] word);
    logic [15:0] acc;
    logic        fb;
    acc = CRC_SEED;
    for (int b = DATA_W - 1; b >= 0; b--) begin
      fb  = acc[15] ^ word[b];
      acc = {acc[14:0], 1'b0};
      if (fb) acc = acc ^ CRC_POLY;
    end
    return acc;
  endfunction

  // persistent cell array (cleared only by blankN)
  logic [NUM_LINES-1:0] cellUsed;
  logic [DATA_W-1:0]    cellData [NUM_LINES];
  logic [15:0]          cellCrc  [NUM_LINES];
  logic [CNT_W-1:0]     cellSeq  [NUM_LINES];
  logic [NUM_LINES-1:0] lineCrcOk;

  // volatile write-in-progress record
  logic [LINE_W-1:0] pendLine;
  logic [15:0]       pendCrc;

  logic [CNT_W-1:0]  usedCount;
  logic [CNT_W-1:0]  nextSeq;
  logic [LINE_W-1:0] newestIdx;
  logic [CNT_W-1:0]  newestSeq;
  logic              anyUsed;
  logic              tgtInRange;
  logic              tgtUsed;
  logic              tgtCrcOk;
  logic [DATA_W-1:0] tgtData;

  assign nextSeq = usedCount + 1'b1;

  for (genvar i = 0; i < NUM_LINES; i++) begin : gLine
    localparam logic [LINE_W-1:0] IDX = LINE_W'(i);

    always_ff @(posedge clk or negedge blankN) begin
      if (!blankN) begin
        cellUsed[i] <= 1'b0;
        cellData[i] <= '0;
        cellCrc[i]  <= CRC_BLANK;
        cellSeq[i]  <= '0;
      end else begin
        if (strobe.wrStart && cmdLine == IDX) begin
          cellUsed[i] <= 1'b1;
          cellData[i] <= cmdData;
          cellSeq[i]  <= nextSeq;
        end
        if (strobe.wrCommit && pendLine == IDX) begin
          cellCrc[i] <= pendCrc;
        end
      end
    end

    assign lineCrcOk[i] = cellUsed[i] && (crcOf(cellData[i]) == cellCrc[i]);
  end

  always_comb begin
    usedCount = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      usedCount = usedCount + CNT_W'(cellUsed[i]);
    end
  end

  // newest line: highest write-order stamp among used lines
  always_comb begin
    newestIdx = '0;
    newestSeq = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (cellUsed[i] && cellSeq[i] > newestSeq) begin
        newestIdx = LINE_W'(i);
        newestSeq = cellSeq[i];
      end
    end
  end

  assign anyUsed = |cellUsed;

  always_comb begin
    tgtInRange = 1'b0;
    tgtUsed    = 1'b0;
    tgtCrcOk   = 1'b0;
    tgtData    = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (cmdLine == LINE_W'(i)) begin
        tgtInRange = 1'b1;
        tgtUsed    = cellUsed[i];
        tgtCrcOk   = lineCrcOk[i];
        tgtData    = cellData[i];
      end
    end
  end

  assign wrBlocked = !tgtInRange || tgtUsed || (int'(usedCount) >= NUM_LINES);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      wrErr    <= 1'b0;
      readOk   <= 1'b0;
      readData <= '0;
      cfgOut   <= '0;
      startEn  <= 1'b0;
      crcFail  <= 1'b0;
      pendLine <= '0;
      pendCrc  <= CRC_BLANK;
    end else begin
      if (strobe.ldCapture) begin
        if (anyUsed && lineCrcOk[newestIdx]) begin
          cfgOut  <= cellData[newestIdx];
          startEn <= 1'b1;
          crcFail <= 1'b0;
        end else begin
          cfgOut  <= '0;
          startEn <= 1'b0;
          crcFail <= anyUsed;
        end
      end
      if (strobe.wrStart) begin
        wrErr    <= 1'b0;
        readOk   <= 1'b0;
        pendLine <= cmdLine;
        pendCrc  <= crcOf(cmdData);
      end
      if (strobe.wrReject) begin
        wrErr  <= 1'b1;
        readOk <= 1'b0;
      end
      if (strobe.rdCapture) begin
        wrErr    <= 1'b0;
        readOk   <= tgtCrcOk;
        readData <= tgtData;
      end
    end
  end

  assign linesUsed = usedCount;

endmodule

// File: rtl/cfgstore_top.sv
module cfgstore_top
  import cfgstore_pkg::*;
#(
  parameter int NUM_LINES = 6,
  parameter int DATA_W    = 16,
  parameter int WR_LAT    = 8,
  localparam int LINE_W   = (NUM_LINES < 2) ? 1 : $clog2(NUM_LINES),
  localparam int CNT_W    = $clog2(NUM_LINES + 1)
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              blankN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [LINE_W-1:0] cmdLine,
  input  logic [DATA_W-1:0] cmdData,
  output logic [1:0]        opState,
  output logic              wrErr,
  output logic              readOk,
  output logic [DATA_W-1:0] readData,
  output logic [CNT_W-1:0]  linesUsed,
  output logic [DATA_W-1:0] cfgOut,
  output logic              startEn,
  output logic              crcFail
);

  ctrlStrobe_t strobe;
  opState_e    stateNow;
  logic        wrBlocked;

  cfgstore_ctrl #(.WR_LAT(WR_LAT)) uCtrl (
    .clk      (clk),
    .porN     (porN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .wrBlocked(wrBlocked),
    .opState  (stateNow),
    .strobe   (strobe)
  );

  cfgstore_dp #(
    .NUM_LINES(NUM_LINES),
    .DATA_W   (DATA_W),
    .LINE_W   (LINE_W),
    .CNT_W    (CNT_W)
  ) uDp (
    .clk      (clk),
    .porN     (porN),
    .blankN   (blankN),
    .strobe   (strobe),
    .cmdLine  (cmdLine),
    .cmdData  (cmdData),
    .wrBlocked(wrBlocked),
    .wrErr    (wrErr),
    .readOk   (readOk),
    .readData (readData),
    .linesUsed(linesUsed),
    .cfgOut   (cfgOut),
    .startEn  (startEn),
    .crcFail  (crcFail)
  );

  assign opState = stateNow;

endmodule

// File: rtl/cfgstore_chk.sv
module cfgstore_chk #(
  parameter int NUM_LINES = 6,
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 3
) (
  input logic              clk,
  input logic              porN,
  input logic              blankN,
  input logic              cmdValid,
  input logic [1:0]        cmdOp,
  input logic [1:0]        opState,
  input logic              wrErr,
  input logic [CNT_W-1:0]  linesUsed,
  input logic [DATA_W-1:0] cfgOut,
  input logic              startEn,
  input logic              crcFail
);

  // R1: load lasts a single cycle
  assert_load_single_R1: assert property (@(posedge clk) disable iff (!porN)
    opState == 2'd3 |=> opState == 2'd0);

  // R3: start is never granted together with a CRC failure
  assert_start_clean_R3: assert property (@(posedge clk) disable iff (!porN)
    startEn |-> !crcFail);

  // R4: operating outputs frozen outside the load cycle
  assert_cfg_frozen_R4: assert property (@(posedge clk) disable iff (!porN)
    opState != 2'd3 |=> $stable(cfgOut) && $stable(startEn) && $stable(crcFail));

  // R5: entering WRITE bumps the count by one
  assert_write_counts_R5: assert property (@(posedge clk) disable iff (!porN || !blankN)
    (opState == 2'd1 && $past(opState) == 2'd0) |-> linesUsed == CNT_W'($past(linesUsed) + 1'b1));

  // R5: count bounded by line total
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!blankN)
    int'(linesUsed) <= NUM_LINES);

  // R6: a rejection leaves the count alone and stays idle
  assert_reject_clean_R6: assert property (@(posedge clk) disable iff (!porN || !blankN)
    $rose(wrErr) |-> $stable(linesUsed) && opState == 2'd0);

  // R7: READ lasts one cycle
  assert_read_single_R7: assert property (@(posedge clk) disable iff (!porN)
    opState == 2'd2 |=> opState == 2'd0);

  // R9: ignored opcodes never leave IDLE
  assert_bad_op_idle_R9: assert property (@(posedge clk) disable iff (!porN)
    (opState == 2'd0 && cmdValid && (cmdOp == 2'b00 || cmdOp == 2'b11)) |=> opState == 2'd0);

  // R10: count never falls while cells are kept
  assert_count_kept_R10: assert property (@(posedge clk) disable iff (!blankN)
    linesUsed >= $past(linesUsed));

endmodule

bind cfgstore_top cfgstore_chk #(
  .NUM_LINES(NUM_LINES),
  .DATA_W   (DATA_W),
  .CNT_W    (CNT_W)
) uChk (
  .clk      (clk),
  .porN     (porN),
  .blankN   (blankN),
  .cmdValid (cmdValid),
  .cmdOp    (cmdOp),
  .opState  (opState),
  .wrErr    (wrErr),
  .linesUsed(linesUsed),
  .cfgOut   (cfgOut),
  .startEn  (startEn),
  .crcFail  (crcFail)
);

// File: tb/tb_cfgstore_top.sv
module tb_cfgstore_top;

  localparam int NUM_LINES = 6;
  localparam int DATA_W    = 16;
  localparam int WR_LAT    = 8;

  logic        clk = 1'b0;
  logic        porN, blankN, cmdValid;
  logic [1:0]  cmdOp;
  logic [2:0]  cmdLine;
  logic [15:0] cmdData;
  logic [1:0]  opState;
  logic        wrErr, readOk, startEn, crcFail;
  logic [15:0] readData, cfgOut;
  logic [2:0]  linesUsed;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cfgstore_top #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .WR_LAT(WR_LAT)) dut (
    .clk(clk), .porN(porN), .blankN(blankN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdLine(cmdLine), .cmdData(cmdData), .opState(opState), .wrErr(wrErr),
    .readOk(readOk), .readData(readData), .linesUsed(linesUsed), .cfgOut(cfgOut),
    .startEn(startEn), .crcFail(crcFail)
  );

  function automatic logic [15:0] refCrc(input logic [15:0] w);
    logic [15:0] r;
    r = 16'hFFFF;
    for (int k = 0; k < 16; k++) begin
      if (((r >> 15) ^ (w >> (15 - k))) & 16'd1) r = (r << 1) ^ 16'h1021;
      else r = r << 1;
    end
    return r;
  endfunction

  function automatic logic [15:0] patt(input int k);
    return 16'h5A3C ^ 16'((k + 1) * 4957);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input int line, input logic [15:0] data);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdLine = 3'(line); cmdData = data;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 2'b00;
  endtask

  task automatic waitIdle(output int cyc);
    cyc = 0;
    while (opState != 2'd0) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic powerCycle(input bit blank, output int cyc);
    @(negedge clk);
    porN = 1'b0;
    if (blank) blankN = 1'b0;
    repeat (2) @(negedge clk);
    porN = 1'b1; blankN = 1'b1;
    waitIdle(cyc);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=busy expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int cyc;
    int ord[6];
    logic [15:0] cutWord;
    bit cutOk;
    porN = 1'b0; blankN = 1'b0; cmdValid = 1'b0; cmdOp = 2'b00; cmdLine = '0; cmdData = '0;
    repeat (3) @(negedge clk);
    porN = 1'b1; blankN = 1'b1;
    waitIdle(cyc);
    check("R1", "load cycles", cyc, 1);
    check("R1", "state after load", int'(opState), 0);
    check("R3", "blank startEn", int'(startEn), 0);
    check("R3", "blank crcFail", int'(crcFail), 0);
    check("R10", "blank linesUsed", int'(linesUsed), 0);
    check("R3", "blank cfgOut", int'(cfgOut), 0);

    issue(2'b10, 2, 16'h0);
    waitIdle(cyc);
    check("R7", "read cycles", cyc, 1);
    check("R8", "unused readOk", int'(readOk), 0);

    // fill every line in scrambled order: 1,0,5,4,3,2
    for (int k = 0; k < NUM_LINES; k++) ord[k] = (k * 5 + 1) % NUM_LINES;
    for (int k = 0; k < NUM_LINES; k++) begin
      issue(2'b01, ord[k], patt(k));
      waitIdle(cyc);
      check("R5", "write cycles", cyc, WR_LAT);
      check("R6", "accepted wrErr", int'(wrErr), 0);
      check("R5", "linesUsed", int'(linesUsed), k + 1);
      check("R4", "cfgOut during writes", int'(cfgOut), 0);
      check("R4", "startEn during writes", int'(startEn), 0);
      issue(2'b10, ord[k], 16'h0);
      waitIdle(cyc);
      check("R7", "readback ok", int'(readOk), 1);
      check("R7", "readback data", int'(readData), int'(patt(k)));
      issue(2'b01, ord[k], ~patt(k));
      waitIdle(cyc);
      check("R6", "rewrite wrErr", int'(wrErr), 1);
      check("R6", "rewrite stays idle", cyc, 0);
      check("R6", "rewrite count", int'(linesUsed), k + 1);
      issue(2'b10, ord[k], 16'h0);
      waitIdle(cyc);
      check("R6", "rewrite left data", int'(readData), int'(patt(k)));
      check("R6", "read clears wrErr", int'(wrErr), 0);
    end
    for (int ln = NUM_LINES; ln < 8; ln++) begin
      issue(2'b01, ln, 16'h1234);
      waitIdle(cyc);
      check("R6", "out of range wrErr", int'(wrErr), 1);
      check("R6", "out of range count", int'(linesUsed), NUM_LINES);
    end

    powerCycle(1'b0, cyc);
    check("R1", "reload cycles", cyc, 1);
    check("R10", "count kept", int'(linesUsed), NUM_LINES);
    check("R2", "newest loaded", int'(cfgOut), int'(patt(NUM_LINES - 1)));
    check("R2", "startEn", int'(startEn), 1);
    check("R3", "crcFail clear", int'(crcFail), 0);

    // blank and rebuild
    powerCycle(1'b1, cyc);
    check("R10", "blank clears", int'(linesUsed), 0);
    check("R3", "blank no start", int'(startEn), 0);
    issue(2'b01, 4, patt(10));
    waitIdle(cyc);
    issue(2'b01, 3, patt(11));
    // busy: present further commands while WRITE in progress
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'b01; cmdLine = 3'd0; cmdData = 16'hBEEF;
    @(negedge clk);
    cmdOp = 2'b10; cmdLine = 3'd4;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 2'b00;
    waitIdle(cyc);
    check("R9", "busy write ignored count", int'(linesUsed), 2);
    issue(2'b10, 0, 16'h0);
    waitIdle(cyc);
    check("R9", "busy target unused", int'(readOk), 0);
    issue(2'b11, 5, 16'h7777);
    check("R9", "op 11 idle", int'(opState), 0);
    issue(2'b00, 5, 16'h7777);
    check("R9", "op 00 idle", int'(opState), 0);
    check("R9", "ignored ops count", int'(linesUsed), 2);

    powerCycle(1'b0, cyc);
    check("R2", "order not index", int'(cfgOut), int'(patt(11)));
    check("R2", "start after reload", int'(startEn), 1);

    // WRITE cut off by power-on reset
    cutWord = patt(12);
    cutOk = (refCrc(cutWord) == 16'h0000);
    issue(2'b01, 1, cutWord);
    repeat (3) @(negedge clk);
    check("R11", "still writing", int'(opState), 1);
    porN = 1'b0;
    repeat (2) @(negedge clk);
    porN = 1'b1;
    waitIdle(cyc);
    check("R11", "cut line used", int'(linesUsed), 3);
    check("R11", "cut startEn", int'(startEn), int'(cutOk));
    check("R3", "cut crcFail", int'(crcFail), int'(!cutOk));
    check("R3", "cut cfgOut", int'(cfgOut), cutOk ? int'(cutWord) : 0);
    issue(2'b10, 1, 16'h0);
    waitIdle(cyc);
    check("R11", "cut readOk", int'(readOk), int'(cutOk));
    check("R11", "cut readData", int'(readData), int'(cutWord));
    issue(2'b10, 3, 16'h0);
    waitIdle(cyc);
    check("R7", "intact line ok", int'(readOk), 1);
    issue(2'b01, 1, 16'h4321);
    waitIdle(cyc);
    check("R6", "cut line not rewritable", int'(wrErr), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule